// File: doc/BRIEF.md
# SPI NOR Flash Slave Model

This block is a synthesizable, scaled-down model of a serial NOR flash device. An SPI master talks to it over chip select (active low), serial clock, serial data in and serial data out, in SPI mode 0 with data sent MSB first. The model runs on its own system clock, which must be well above the serial clock. It passes the serial pins through synchronizers and finds the serial clock edges by oversampling.

The storage is a byte array made of 256-byte pages. The pages are grouped into sectors, and the sector count and pages per sector are parameters, so a simulation can use a small array in place of the full 32 × 64 KB part. The model takes single-bit commands for:
- write enable
- page program
- page erase
- sector erase
- bulk erase
- status read
- plain read

Program and erase are not instant. After the frame ends, an internal engine walks the affected bytes one per system clock and then waits a fixed settle time. During that whole period the write-in-progress bit in the status byte reads 1. Software polls that bit to learn when the operation is done.

A program frame only clears bits: each target byte becomes its old value ANDed with the new data. An erase sets the chosen page, sector or whole array back to FFh.

Top module: `flash_model`

## Requirements
- R1: After reset, SO is 0 and a status read (05h) returns 00h. Status bit 0 is write-in-progress (WIP) and bit 1 is the write-enable latch (WEL); all other bits read 0.
- R2: A frame that carries exactly the one byte 06h, while the model is idle, sets WEL.
- R3: Program (02h) and the erase commands (DBh page, D8h sector, C7h bulk) have no effect and start no cycle unless WEL is set.
- R4: Programming stores the old byte ANDed with the new data byte, so it can only clear bits.
- R5: A program frame is 02h, three address bytes (MSB first), then one or more data bytes. The data bytes go to consecutive columns of the addressed 256-byte page. After column FFh the next byte goes to column 00h of the same page.
- R6: Page erase and sector erase each take three address bytes; bulk erase is the opcode alone. They set every byte of the addressed page, of the addressed sector (PAGES_PER_SECTOR pages) or of the whole array to FFh, and leave every other byte unchanged.
- R7: WIP reads 1 from the end of an accepted program or erase frame until its cycle is complete. When the cycle completes, WIP and WEL both clear.
- R8: While WIP is 1, every opcode except 05h is ignored. A write enable sent then does not set WEL, and a read sent then returns 00h.
- R9: A cycle starts only when CS# rises after a whole number of bytes. A frame that ends part-way through a byte changes nothing in the array and leaves WEL as it was.
- R10: Read (03h) followed by a 3-byte address returns the stored bytes from that address upward, MSB first, with SO changing after the falling SCK edge. The address wraps from the last byte of the array to byte 0.
- R11: Within one frame, a status read repeats the live status byte for as long as clocks continue.
- R12: Address bits above the array size are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be at least 8× the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; framing of each command |
| sck | input | 1 | Serial clock, SPI mode 0 |
| si | input | 1 | Serial data from the master, sampled on rising SCK |
| so | output | 1 | Serial data to the master, updated after falling SCK |

## Verification
Every serial pin passes through two synchronizer stages and one edge-detect register. A data-out bit therefore appears three system clocks after the falling SCK edge that calls for it. The bench holds each SCK phase for six clocks and samples SO just before it raises SCK. A command takes effect three clocks after CS# rises. The bench leaves eighteen clocks before the next frame, so the first status byte of the following frame already shows WIP. A busy period lasts one clock per byte in the affected range plus the settle count. The bench polls status until WIP clears and checks each polled byte against the behavioural array, latch and busy flags it keeps. It reads back every affected byte against its own model, and places the busy-time commands within the known length of a sector erase.

// File: rtl/flashm_pkg.sv
// Package: shared opcodes and state types for the serial flash model.
// Assumes: single-bit SPI mode 0 framing, MSB first.
package flashm_pkg;
    localparam logic [7:0] OP_NONE   = 8'h00;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_PERASE = 8'hDB;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_BERASE = 8'hC7;

    typedef enum logic [1:0] {
        ER_PAGE,
        ER_SECTOR,
        ER_ALL
    } erase_kind_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_PROG,
        ENG_ERASE,
        ENG_SETTLE
    } eng_state_t;
endpackage

// File: rtl/flash_spi_front.sv
// Module: serial front end. It synchronizes CS#, SCK and SI to clk, finds the SCK
// edges, assembles received bytes and shifts transmit bytes out on SO.
// Assumes: clk is at least 8x SCK; SPI mode 0 (sample on rise, drive after fall).
module flash_spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic [7:0] tx_byte,
    output logic       so,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       frame_end,
    output logic       aligned,
    output logic       tx_load
);
    logic [SYNC_STAGES-1:0] cs_sync, sck_sync, si_sync;
    logic cs_now, sck_now, si_now;
    logic cs_q, sck_q;
    logic rise, fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;

    assign cs_now  = cs_sync[SYNC_STAGES-1];
    assign sck_now = sck_sync[SYNC_STAGES-1];
    assign si_now  = si_sync[SYNC_STAGES-1];

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sync  <= '1;
            sck_sync <= '0;
            si_sync  <= '0;
            cs_q     <= 1'b1;
            sck_q    <= 1'b0;
        end else begin
            cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
            si_sync  <= {si_sync[SYNC_STAGES-2:0], si};
            cs_q     <= cs_now;
            sck_q    <= sck_now;
        end
    end

    assign rise      = !cs_now && sck_now && !sck_q;
    assign fall      = !cs_now && !sck_now && sck_q;
    assign frame_end = cs_now && !cs_q;
    assign aligned   = (bit_cnt == 3'd0);
    assign tx_load   = fall && (bit_cnt == 3'd0);

    // Receive shifter and bit counter; cleared while the chip is deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_now) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (rise) begin
            rx_sh   <= {rx_sh[6:0], si_now};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Registered byte-complete pulse and the byte it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= rise && (bit_cnt == 3'd7);
            if (rise && (bit_cnt == 3'd7)) begin
                rx_byte <= {rx_sh[6:0], si_now};
            end
        end
    end

    // Transmit shifter: loads a fresh byte on the first fall of each byte slot.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_now) begin
            so    <= 1'b0;
            tx_sh <= '0;
        end else if (fall) begin
            if (bit_cnt == 3'd0) begin
                so    <= tx_byte[7];
                tx_sh <= {tx_byte[6:0], 1'b0};
            end else begin
                so    <= tx_sh[7];
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    // SO may change only on a falling SCK edge while selected.
    assert_so_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_now && !fall) |=> $stable(so));
endmodule

// File: rtl/flash_cmd.sv
// Module: command decoder. It tracks the byte position in a frame, collects the
// address, keeps the write-enable latch, steers program data into the page
// buffer and issues program or erase starts at the end of a frame.
// Assumes: bytes arrive as rx_valid pulses; frame_end marks CS# rising.
module flash_cmd
    import flashm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frame_end,
    input  logic              aligned,
    input  logic              tx_load,
    input  logic              busy,
    input  logic              eng_done,
    input  logic [7:0]        rd_data,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [PAGE_W-1:0] buf_col,
    output logic [7:0]        buf_data,
    output logic              start_prog,
    output logic              start_erase,
    output erase_kind_t       erase_kind,
    output logic [ADDR_W-1:0] op_addr
);
    logic [2:0]        idx;
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] addr_sh;
    logic [PAGE_W-1:0] col;
    logic              wel;
    logic              whole_end;
    logic              wel_set;
    logic              read_phase;
    logic              addr_cmd;
    logic              bare_cmd;

    assign read_phase = (opcode == OP_READ) && (idx >= 3'd4);
    assign buf_clr    = rx_valid && (idx == 3'd3);
    assign buf_we     = rx_valid && (idx >= 3'd4) && (opcode == OP_PROG) && wel;
    assign buf_col    = col;
    assign buf_data   = rx_byte;
    assign op_addr    = addr_sh;
    assign rd_addr    = rd_ptr_q;

    // Byte position, opcode capture and address assembly within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            idx    <= '0;
            opcode <= OP_NONE;
        end else if (rx_valid) begin
            if (idx != 3'd5) begin
                idx <= idx + 3'd1;
            end
            if (idx == 3'd0) begin
                opcode <= (busy && (rx_byte != OP_RDSR)) ? OP_NONE : rx_byte;
            end
        end
    end

    // Address register and program column pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh <= '0;
            col     <= '0;
        end else if (rx_valid) begin
            if ((idx >= 3'd1) && (idx <= 3'd3)) begin
                addr_sh <= ADDR_W'({addr_sh, rx_byte});
            end
            if (idx == 3'd3) begin
                col <= PAGE_W'(rx_byte);
            end else if (buf_we) begin
                col <= col + 1'b1;
            end
        end
    end

    logic [ADDR_W-1:0] rd_ptr_q;

    // Read pointer: loaded with the full address, advanced per output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
        end else if (rx_valid && (idx == 3'd3)) begin
            rd_ptr_q <= ADDR_W'({addr_sh, rx_byte});
        end else if (tx_load && read_phase) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    // Outgoing byte: live status, array data or zeros.
    always_comb begin
        if ((opcode == OP_RDSR) && (idx >= 3'd1)) begin
            tx_byte = {6'b0, wel, busy};
        end else if (read_phase) begin
            tx_byte = rd_data;
        end else begin
            tx_byte = 8'h00;
        end
    end

    assign whole_end = frame_end && aligned && !busy;
    assign addr_cmd  = ((opcode == OP_PERASE) || (opcode == OP_SERASE)) && (idx == 3'd4);
    assign bare_cmd  = (opcode == OP_BERASE) && (idx == 3'd1);
    assign wel_set   = whole_end && (opcode == OP_WREN) && (idx == 3'd1);
    assign start_prog  = whole_end && wel && (opcode == OP_PROG) && (idx == 3'd5);
    assign start_erase = whole_end && wel && (addr_cmd || bare_cmd);

    // Erase range selection from the accepted opcode.
    always_comb begin
        if (opcode == OP_BERASE) begin
            erase_kind = ER_ALL;
        end else if (opcode == OP_SERASE) begin
            erase_kind = ER_SECTOR;
        end else begin
            erase_kind = ER_PAGE;
        end
    end

    // Write-enable latch: set by a lone write enable, cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (eng_done) begin
            wel <= 1'b0;
        end else if (wel_set) begin
            wel <= 1'b1;
        end
    end

    // Modifying commands only start with the latch set.
    assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> wel);
    // The latch cannot be newly set during a busy period.
    assert_busy_blocks_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(wel));
    // The latch is clear after a cycle completes.
    assert_wel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !wel);
endmodule

// File: rtl/flash_store.sv
// Module: byte array, page buffer and program/erase engine. A program walks the
// whole page ANDing buffered bytes into the array; an erase walks its range
// writing FFh; both then wait SETTLE_CYCLES before reporting done.
// Assumes: DEPTH and the sector size are powers of two; starts arrive only when idle.
module flash_store
    import flashm_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int PAGE_W        = 8,
    parameter int SECTOR_BYTES  = 1024,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [PAGE_W-1:0] buf_col,
    input  logic [7:0]        buf_data,
    input  logic              start_prog,
    input  logic              start_erase,
    input  erase_kind_t       erase_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              eng_done
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SET_W      = $clog2(SETTLE_CYCLES + 1);
    localparam logic [ADDR_W-1:0] PAGE_LAST   = ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] SECTOR_LAST = ADDR_W'(SECTOR_BYTES - 1);
    localparam logic [ADDR_W-1:0] ALL_LAST    = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK   = ~PAGE_LAST;
    localparam logic [ADDR_W-1:0] SECTOR_MASK = ~SECTOR_LAST;
    localparam logic [SET_W-1:0]  SETTLE_LAST = SET_W'(SETTLE_CYCLES - 1);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    eng_state_t            state;
    logic [ADDR_W-1:0]     walk;
    logic [ADDR_W-1:0]     left;
    logic [SET_W-1:0]      settle;
    logic [PAGE_W-1:0]     walk_col;
    logic [7:0]            prog_val;

    assign walk_col = walk[PAGE_W-1:0];
    assign prog_val = pmask[walk_col] ? pbuf[walk_col] : 8'hFF;
    assign rd_data  = mem[rd_addr];
    assign busy     = (state != ENG_IDLE);
    assign eng_done = (state == ENG_SETTLE) && (settle == '0);

    // Page buffer data; the last byte sent to a column wins.
    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf[buf_col] <= buf_data;
        end
    end

    // Column-valid mask: cleared per frame, set on buffer writes, consumed by the walk.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clr) begin
            pmask <= '0;
        end else begin
            if (buf_we) begin
                pmask[buf_col] <= 1'b1;
            end
            if (state == ENG_PROG) begin
                pmask[walk_col] <= 1'b0;
            end
        end
    end

    // Array writes: AND-in for program, all-ones for erase.
    always_ff @(posedge clk) begin
        if (state == ENG_PROG) begin
            mem[walk] <= mem[walk] & prog_val;
        end else if (state == ENG_ERASE) begin
            mem[walk] <= 8'hFF;
        end
    end

    // Engine sequencing: range walk followed by the settle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            walk   <= '0;
            left   <= '0;
            settle <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start_prog) begin
                        walk  <= op_addr & PAGE_MASK;
                        left  <= PAGE_LAST;
                        state <= ENG_PROG;
                    end else if (start_erase) begin
                        state <= ENG_ERASE;
                        unique case (erase_kind)
                            ER_ALL: begin
                                walk <= '0;
                                left <= ALL_LAST;
                            end
                            ER_SECTOR: begin
                                walk <= op_addr & SECTOR_MASK;
                                left <= SECTOR_LAST;
                            end
                            default: begin
                                walk <= op_addr & PAGE_MASK;
                                left <= PAGE_LAST;
                            end
                        endcase
                    end
                end
                ENG_PROG, ENG_ERASE: begin
                    walk <= walk + 1'b1;
                    left <= left - 1'b1;
                    if (left == '0) begin
                        state  <= ENG_SETTLE;
                        settle <= SETTLE_LAST;
                    end
                end
                default: begin
                    if (settle == '0) begin
                        state <= ENG_IDLE;
                    end else begin
                        settle <= settle - 1'b1;
                    end
                end
            endcase
        end
    end

    // A start is only issued to an idle engine.
    assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> (state == ENG_IDLE));
    // An accepted start makes the model busy on the next cycle.
    assert_busy_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |=> busy);
endmodule

// File: rtl/flash_model.sv
// Module: top of the serial NOR flash model. It ties the serial front end, the
// command decoder and the storage engine together.
// Assumes: SECTORS and PAGES_PER_SECTOR are powers of two; clk is at least 8x SCK.
module flash_model #(
    parameter int SECTORS          = 2,
    parameter int PAGES_PER_SECTOR = 4,
    parameter int SETTLE_CYCLES    = 16,
    parameter int SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so
);
    import flashm_pkg::*;

    localparam int PAGE_W       = 8;
    localparam int PAGE_BYTES   = 1 << PAGE_W;
    localparam int SECTOR_BYTES = PAGES_PER_SECTOR * PAGE_BYTES;
    localparam int DEPTH        = SECTORS * SECTOR_BYTES;
    localparam int ADDR_W       = $clog2(DEPTH);

    logic              rx_valid, frame_end, aligned, tx_load;
    logic [7:0]        rx_byte, tx_byte, rd_data, buf_data;
    logic [ADDR_W-1:0] rd_addr, op_addr;
    logic              buf_clr, buf_we, start_prog, start_erase, busy, eng_done;
    logic [PAGE_W-1:0] buf_col;
    erase_kind_t       erase_kind;

    flash_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .tx_byte(tx_byte), .so(so), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_end(frame_end), .aligned(aligned), .tx_load(tx_load)
    );

    flash_cmd #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_end(frame_end), .aligned(aligned), .tx_load(tx_load),
        .busy(busy), .eng_done(eng_done), .rd_data(rd_data), .tx_byte(tx_byte),
        .rd_addr(rd_addr), .buf_clr(buf_clr), .buf_we(buf_we), .buf_col(buf_col),
        .buf_data(buf_data), .start_prog(start_prog), .start_erase(start_erase),
        .erase_kind(erase_kind), .op_addr(op_addr)
    );

    flash_store #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .SECTOR_BYTES(SECTOR_BYTES), .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_col(buf_col), .buf_data(buf_data), .start_prog(start_prog),
        .start_erase(start_erase), .erase_kind(erase_kind), .op_addr(op_addr),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .eng_done(eng_done)
    );
endmodule

// File: tb/flash_model_bench.sv
`timescale 1ns/1ps
// Bench: drives SPI frames and compares every returned byte with a behavioural
// model (array, latch and busy flags) kept in integers and byte arrays.
module flash_model_bench;
    localparam int SECTORS  = 2;
    localparam int PPS      = 4;
    localparam int SETTLE   = 16;
    localparam int SEC_SZ   = PPS * 256;
    localparam int DEPTH    = SECTORS * SEC_SZ;
    localparam int HALF     = 6;
    localparam int POLL_MAX = 60;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so;

    always #2 clk = ~clk;

    flash_model #(
        .SECTORS(SECTORS), .PAGES_PER_SECTOR(PPS), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)
    ) u_flash_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [DEPTH];
    bit ref_wel = 1'b0;
    bit ref_busy = 1'b0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_end();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    // Shift nb bits of tx (MSB first) and capture SO just before each rise.
    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            si = tx[i];
            tick(HALF);
            rx[i] = so;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xfer(op, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
    endtask

    task automatic do_wren();
        logic [7:0] r;
        cs_begin();
        xfer(8'h06, r);
        cs_end();
        if (!ref_busy) ref_wel = 1'b1;
    endtask

    task automatic model_prog(input logic [23:0] a, input logic [31:0] dat, input int n);
        int pg, col;
        pg  = (int'(a) % DEPTH) & ~255;
        col = int'(a) & 255;
        for (int i = 0; i < n; i++) begin
            ref_mem[pg + col] = ref_mem[pg + col] & dat[8*(n-1-i) +: 8];
            col = (col + 1) & 255;
        end
    endtask

    task automatic do_prog(input logic [23:0] a, input logic [31:0] dat, input int n);
        logic [7:0] r;
        cs_begin();
        send_hdr(8'h02, a);
        for (int i = 0; i < n; i++) xfer(dat[8*(n-1-i) +: 8], r);
        cs_end();
        if (ref_wel && !ref_busy) begin
            model_prog(a, dat, n);
            ref_busy = 1'b1;
        end
    endtask

    task automatic do_erase(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        int base, len;
        cs_begin();
        if (op == 8'hC7) xfer(op, r);
        else send_hdr(op, a);
        cs_end();
        if (ref_wel && !ref_busy) begin
            if (op == 8'hC7) begin base = 0; len = DEPTH; end
            else if (op == 8'hD8) begin base = (int'(a) % DEPTH) & ~(SEC_SZ - 1); len = SEC_SZ; end
            else begin base = (int'(a) % DEPTH) & ~255; len = 256; end
            for (int i = 0; i < len; i++) ref_mem[base + i] = 8'hFF;
            ref_busy = 1'b1;
        end
    endtask

    task automatic do_read(input string req, input logic [23:0] a, input int n);
        logic [7:0] r;
        cs_begin();
        send_hdr(8'h03, a);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            check(req, $sformatf("read @%06h+%0d", a, i), r,
                  ref_busy ? 8'h00 : ref_mem[(int'(a) + i) % DEPTH]);
        end
        cs_end();
    endtask

    task automatic do_status(input string req, input int n);
        logic [7:0] r;
        cs_begin();
        xfer(8'h05, r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            check(req, $sformatf("status byte %0d", i), r, {6'b0, ref_wel, ref_busy});
        end
        cs_end();
    endtask

    // Poll status until WIP clears; every polled byte must be 03h or the final 00h.
    task automatic wait_done(input string req);
        logic [7:0] st;
        int polls;
        polls = 0;
        cs_begin();
        xfer(8'h05, st);
        xfer(8'h00, st);
        check(req, "first poll", st, {6'b0, ref_wel, ref_busy});
        while (st[0] && polls < POLL_MAX) begin
            xfer(8'h00, st);
            polls++;
            if (st != 8'h03 && st != 8'h00) check(req, "busy poll", st, 8'h03);
        end
        cs_end();
        ref_busy = 1'b0;
        ref_wel = 1'b0;
        check(req, "status after cycle", st, 8'h00);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        check("R1", "so after reset", {7'b0, so}, 8'h00);
        do_status("R1", 1);

        // R3: bulk erase without write enable starts nothing
        do_erase(8'hC7, 24'h0);
        do_status("R3", 1);

        // R2, R11: write enable sets WEL; status repeats in one frame
        do_wren();
        do_status("R2_R11", 2);

        // R6, R7: bulk erase runs, WIP shows, then WIP and WEL clear
        do_erase(8'hC7, 24'h0);
        wait_done("R7");
        do_read("R6", 24'h000000, 2);
        do_read("R6", 24'(DEPTH - 2), 2);

        // R5: page wrap inside page 1
        do_wren();
        do_prog(24'h0001FE, 32'hA53C0FF0, 4);
        wait_done("R7");
        do_read("R5", 24'h000100, 2);
        do_read("R5", 24'h0001FE, 3);

        // R4: second program ANDs with old contents
        do_wren();
        do_prog(24'h0001FE, 32'h000000F0, 1);
        wait_done("R7");
        do_read("R4", 24'h0001FE, 1);

        // R3: program without WEL is ignored
        do_prog(24'h000100, 32'h00000000, 1);
        do_status("R3", 1);
        do_read("R3", 24'h000100, 1);

        // Populate page 2 (sector 0) and page 4 (sector 1)
        do_wren();
        do_prog(24'h000200, 32'h00001122, 2);
        wait_done("R7");
        do_wren();
        do_prog(24'h000400, 32'h00000044, 1);
        wait_done("R7");

        // R9: frame ending mid-byte changes nothing and keeps WEL
        do_wren();
        cs_begin();
        send_hdr(8'h02, 24'h000300);
        xfer(8'h5A, r);
        xbits(8'hF0, 4, r);
        cs_end();
        do_status("R9", 2);
        do_read("R9", 24'h000300, 1);
        do_prog(24'h000300, 32'h0000005A, 1);
        wait_done("R9");
        do_read("R9", 24'h000300, 1);

        // R6: page erase of page 1 only
        do_wren();
        do_erase(8'hDB, 24'h000155);
        wait_done("R7");
        do_read("R6", 24'h000100, 2);
        do_read("R6", 24'h0001FF, 1);
        do_read("R6", 24'h000200, 2);

        // R8: during a sector erase, write enable and read are ignored
        do_wren();
        do_erase(8'hD8, 24'h000123);
        do_wren();
        do_read("R8", 24'h000400, 1);
        wait_done("R8");
        do_read("R6", 24'h000200, 1);
        do_read("R6", 24'h000300, 1);
        do_read("R6", 24'h000400, 1);

        // R12: upper address bits ignored
        do_read("R12", 24'hFF0400, 1);

        // R10, R5: wrap at end of page and at end of array
        do_wren();
        do_prog(24'(DEPTH - 1), 32'h00009669, 2);
        wait_done("R7");
        do_read("R10", 24'(DEPTH - 1), 2);
        do_read("R5", 24'(DEPTH - 256), 1);

        summary();
        $finish;
    end
endmodule